// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses, on every clock, the control-memory address of the next microinstruction in a microprogrammed control unit. It holds a 7-bit control address register and a small control store. The word at the current address drives three fields: a condition select, a branch kind and a target address. A four-way multiplexer then reloads the control address register from one of four values: the incremented address, the target field, an address formed from the external opcode, or a single-level return register.

A two-bit selector picks one status input, or a constant one, as the branch condition. Conditional jumps and conditional calls use this condition. When it is false they fall through to the next sequential address. A taken call stores the address after the call in the return register, and a return reloads the control address from that register.

The control store is loaded through a plain write port, normally while reset is held. Decoding of the microoperation fields and the datapath they steer belong to other blocks.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the control address and the return register both become 0 at that edge.
- R2: Branch kind 00 is a conditional jump. When the selected condition is 1, the next control address equals the word's target field.
- R3: For branch kind 00 or 01 with a false condition, the next control address is the current address plus one, modulo 128, so 127 is followed by 0.
- R4: Branch kind 01 is a conditional call. When the condition is 1, the control address loads the target field and the return register loads the current address plus one, modulo 128.
- R5: Branch kind 10 is a return. The next control address equals the return register, whatever the condition is.
- R6: Branch kind 11 is a map. The next control address is bit 6 = 0, bits 5..2 = `opcode`, and bits 1..0 = 00.
- R7: The condition select field picks the condition: 00 gives constant 1, 01 gives `st_sign`, 10 gives `st_zero`, and 11 gives `st_ind`. The result appears on `cond_true`.
- R8: The return register keeps its value on every cycle that is not a taken call.
- R9: When `cm_wr_en` is high at a clock edge, `cm_wr_data` is stored at `cm_wr_addr`. The outputs show the word at the current control address without delay. The word layout is bits 10..9 = condition select, bits 8..7 = branch kind, and bits 6..0 = target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cm_wr_en | input | 1 | Control-store write enable |
| cm_wr_addr | input | 7 | Control-store write address |
| cm_wr_data | input | 11 | Control-store write word |
| opcode | input | 4 | External opcode used by map |
| st_sign | input | 1 | Sign status bit |
| st_zero | input | 1 | Zero status bit |
| st_ind | input | 1 | Indirect status bit |
| ctl_addr | output | 7 | Current control address |
| ret_addr | output | 7 | Return register contents |
| uw_cond_sel | output | 2 | Condition select of current word |
| uw_kind | output | 2 | Branch kind of current word |
| uw_target | output | 7 | Target field of current word |
| cond_true | output | 1 | Selected condition value |

## Verification
On every cycle the assertions check each next-address rule against the word and condition of the previous cycle: taken jumps, fall-through with wrap, call saves, returns, opcode mapping, the hold of the return register, and the constant-one condition. Only the bench's scenarios can show that the control store keeps the words written to it and returns them at the right address. They also show that real instruction flows, such as a call, return, map and wrap chain, or random programs under changing status bits, visit the addresses a behavioural model predicts.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int ADDR_W = 7;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;
  localparam int KIND_W = 2;
  localparam int WORD_W = SEL_W + KIND_W + ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [KIND_W-1:0] {
    BR_JUMP = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } br_kind_e;

  typedef enum logic [SEL_W-1:0] {
    CS_ONE  = 2'b00,
    CS_SIGN = 2'b01,
    CS_ZERO = 2'b10,
    CS_IND  = 2'b11
  } cond_src_e;

  typedef struct packed {
    cond_src_e             sel;
    br_kind_e              kind;
    logic [ADDR_W-1:0]     target;
  } uword_t;

  // sequential successor, wraps at the top of the store
  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // opcode placed above two zero bits, upper bits zero
  function automatic logic [ADDR_W-1:0] opcode_map(input logic [OP_W-1:0] op);
    logic [ADDR_W-1:0] r;
    r = '0;
    r[OP_W+1:2] = op;
    return r;
  endfunction
endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output uword_t            rd_word
);
  uword_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= uword_t'(wr_data);
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
(
  input  cond_src_e sel,
  input  logic      st_sign,
  input  logic      st_zero,
  input  logic      st_ind,
  output logic      cond
);
  always_comb begin
    unique case (sel)
      CS_ONE:  cond = 1'b1;
      CS_SIGN: cond = st_sign;
      CS_ZERO: cond = st_zero;
      default: cond = st_ind;
    endcase
  end

  // R7
  always_comb begin
    if (sel == CS_SIGN && !st_sign) cond_sign_chk: assert (!cond);
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  uword_t            word,
  input  logic              cond,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car_q,
  output logic [ADDR_W-1:0] sbr_q
);
  logic [ADDR_W-1:0] car_d, sbr_d, car_inc;
  logic              jump_taken, call_taken, fall_thru, is_ret, is_map;

  assign car_inc    = addr_step(car_q);
  assign jump_taken = (word.kind == BR_JUMP) && cond;
  assign call_taken = (word.kind == BR_CALL) && cond;
  assign fall_thru  = ((word.kind == BR_JUMP) || (word.kind == BR_CALL)) && !cond;
  assign is_ret     = (word.kind == BR_RET);
  assign is_map     = (word.kind == BR_MAP);

  always_comb begin
    sbr_d = sbr_q;
    car_d = car_inc;
    if (jump_taken || call_taken) car_d = word.target;
    else if (is_ret)              car_d = sbr_q;
    else if (is_map)              car_d = opcode_map(opcode);
    if (call_taken) sbr_d = car_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car_q <= '0;
      sbr_q <= '0;
    end else begin
      car_q <= car_d;
      sbr_q <= sbr_d;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (car_q == '0 && sbr_q == '0));
  // R2
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    jump_taken |=> car_q == $past(word.target));
  // R3
  fall_step_chk: assert property (@(posedge clk) disable iff (rst)
    fall_thru |=> car_q == ADDR_W'($past(car_q) + 1));
  // R4
  call_save_chk: assert property (@(posedge clk) disable iff (rst)
    call_taken |=> (sbr_q == ADDR_W'($past(car_q) + 1) && car_q == $past(word.target)));
  // R5
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    is_ret |=> car_q == $past(sbr_q));
  // R6
  map_addr_chk: assert property (@(posedge clk) disable iff (rst)
    is_map |=> (car_q[1:0] == 2'b00 && car_q[ADDR_W-1] == 1'b0 &&
                car_q[OP_W+1:2] == $past(opcode)));
  // R8
  ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !call_taken |=> $stable(sbr_q));
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cm_wr_en,
  input  logic [ADDR_W-1:0] cm_wr_addr,
  input  logic [WORD_W-1:0] cm_wr_data,
  input  logic [OP_W-1:0]   opcode,
  input  logic              st_sign,
  input  logic              st_zero,
  input  logic              st_ind,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [SEL_W-1:0]  uw_cond_sel,
  output logic [KIND_W-1:0] uw_kind,
  output logic [ADDR_W-1:0] uw_target,
  output logic              cond_true
);
  uword_t            cur_word;
  logic              cond;
  logic [ADDR_W-1:0] car, sbr;

  useq_ctrl_store u_store (
    .clk     (clk),
    .wr_en   (cm_wr_en),
    .wr_addr (cm_wr_addr),
    .wr_data (cm_wr_data),
    .rd_addr (car),
    .rd_word (cur_word)
  );

  useq_cond_sel u_cond (
    .sel     (cur_word.sel),
    .st_sign (st_sign),
    .st_zero (st_zero),
    .st_ind  (st_ind),
    .cond    (cond)
  );

  useq_next_addr u_next (
    .clk    (clk),
    .rst    (rst),
    .word   (cur_word),
    .cond   (cond),
    .opcode (opcode),
    .car_q  (car),
    .sbr_q  (sbr)
  );

  assign ctl_addr    = car;
  assign ret_addr    = sbr;
  assign uw_cond_sel = cur_word.sel;
  assign uw_kind     = cur_word.kind;
  assign uw_target   = cur_word.target;
  assign cond_true   = cond;

  // R7
  always_comb begin
    if (!rst && uw_cond_sel == 2'b00) cond_one_chk: assert (cond_true);
  end
endmodule

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cm_wr_en = 1'b0;
  logic [6:0]  cm_wr_addr = '0;
  logic [10:0] cm_wr_data = '0;
  logic [3:0]  opcode = '0;
  logic        st_sign = 1'b0, st_zero = 1'b0, st_ind = 1'b0;
  logic [6:0]  ctl_addr, ret_addr, uw_target;
  logic [1:0]  uw_cond_sel, uw_kind;
  logic        cond_true;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [10:0] mdl_mem [128];
  int mdl_car, mdl_ret;

  useq_sequencer u_dut (
    .clk(clk), .rst(rst), .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr),
    .cm_wr_data(cm_wr_data), .opcode(opcode), .st_sign(st_sign),
    .st_zero(st_zero), .st_ind(st_ind), .ctl_addr(ctl_addr), .ret_addr(ret_addr),
    .uw_cond_sel(uw_cond_sel), .uw_kind(uw_kind), .uw_target(uw_target),
    .cond_true(cond_true)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] mk(input int sel, input int kind, input int tgt);
    return {sel[1:0], kind[1:0], tgt[6:0]};
  endfunction

  // load the whole store while reset is held, then check reset state
  task automatic load_and_reset(input bit random_fill);
    rst = 1'b1;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      if (random_fill) mdl_mem[a] = 11'($urandom);
      cm_wr_en = 1'b1; cm_wr_addr = 7'(a); cm_wr_data = mdl_mem[a];
    end
    @(negedge clk);
    cm_wr_en = 1'b0;
    @(negedge clk);
    check("R1 car", ctl_addr, 0);
    check("R1 ret", ret_addr, 0);
    mdl_car = 0; mdl_ret = 0;
    rst = 1'b0;
  endtask

  task automatic run(input int cycles, input bit random_in);
    for (int c = 0; c < cycles; c++) begin
      int sel, kind, tgt, nxt_car, nxt_ret;
      bit cnd;
      string tag;
      if (random_in) begin
        opcode = 4'($urandom); st_sign = 1'($urandom);
        st_zero = 1'($urandom); st_ind = 1'($urandom);
      end
      #1;
      sel  = int'(mdl_mem[mdl_car][10:9]);
      kind = int'(mdl_mem[mdl_car][8:7]);
      tgt  = int'(mdl_mem[mdl_car][6:0]);
      check("R9 sel", uw_cond_sel, sel);
      check("R9 kind", uw_kind, kind);
      check("R9 target", uw_target, tgt);
      cnd = (sel == 0) ? 1'b1 : (sel == 1) ? st_sign : (sel == 2) ? st_zero : st_ind;
      check("R7 cond", cond_true, cnd);
      nxt_ret = mdl_ret;
      if (kind == 2) begin
        nxt_car = mdl_ret; tag = "R5 return";
      end else if (kind == 3) begin
        nxt_car = opcode * 4; tag = "R6 map";
      end else if (!cnd) begin
        nxt_car = (mdl_car + 1) % 128; tag = "R3 fall through";
      end else if (kind == 1) begin
        nxt_ret = (mdl_car + 1) % 128; nxt_car = tgt; tag = "R4 call";
      end else begin
        nxt_car = tgt; tag = "R2 jump";
      end
      @(negedge clk);
      mdl_car = nxt_car; mdl_ret = nxt_ret;
      check(tag, ctl_addr, mdl_car);
      check((kind == 1 && cnd) ? "R4 ret save" : "R8 ret hold", ret_addr, mdl_ret);
    end
  endtask

  initial begin
    // directed flow: fall-through call, map, jump, call, return, wrap
    for (int a = 0; a < 128; a++) mdl_mem[a] = mk(0, 0, 0);
    mdl_mem[0]   = mk(2, 1, 50);   // call on zero (false) -> 1
    mdl_mem[1]   = mk(0, 3, 0);    // map opcode 3 -> 12
    mdl_mem[12]  = mk(0, 0, 10);   // jump -> 10
    mdl_mem[10]  = mk(0, 1, 40);   // call -> 40, ret 11
    mdl_mem[40]  = mk(3, 2, 99);   // return -> 11
    mdl_mem[11]  = mk(1, 0, 127);  // jump on sign -> 127
    mdl_mem[127] = mk(2, 0, 3);    // zero false -> wrap to 0
    opcode = 4'd3; st_sign = 1'b1; st_zero = 1'b0; st_ind = 1'b1;
    load_and_reset(1'b0);
    run(40, 1'b0);
    // random programs and random status
    for (int p = 0; p < 3; p++) begin
      load_and_reset(1'b1);
      run(3000, 1'b1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule